// File: doc/BRIEF.md
# DMA Burst Length Sequencer

This block turns a single DMA access request into a counted run of bus beats. A one-cycle start pulse latches the kind of access (descriptor field or data buffer), the transfer direction and a six-bit burst length code. The block then offers beats one at a time on a valid/ready pair until the burst is complete. When a burst ends, the block raises a one-cycle completion pulse and goes back to waiting for the next request. Address generation and the bus protocol sit outside the block.

A descriptor access always moves exactly one 32-bit field, so its beat count comes from the bus width parameter alone. A data access uses the programmed length. A length of zero sets no beat limit: the burst then runs until the data FIFO cannot take or supply another word. Counted data bursts stop at the same FIFO limit, so the FIFO never overflows or underflows. Back-pressure works as follows. A beat moves only in a cycle where `beat_valid_o` and `beat_ready_i` are both high. While ready is low, an offered beat stays offered unless the FIFO limit ends the burst. The FIFO flags are sampled in every cycle of a data burst.

Top module: `dma_burst_seq`

## Requirements
- R1: While reset is held and in the first cycles after it, `beat_valid_o`, `beat_last_o` and `done_o` are low.
- R2: A descriptor access (`desc_sel_i`=1) makes exactly 32/DATA_W beats, marks the last of them, and ignores both FIFO flags.
- R3: A data access with length code 1, 2, 4, 8, 16 or 32 makes exactly that many beats when the FIFO never limits it. `beat_last_o` is high only with the final beat.
- R4: A nonzero length code that is not a power of two is rounded down to the highest power of two not above it (3→2, 5→4, 40→32, 63→32).
- R5: A data length code of 0 sets no beat limit. The burst ends at the FIFO limit, and `beat_last_o` stays low for the whole burst.
- R6: The FIFO limit is `fifo_full_i` when `tx_dir_i`=1 (transmit) and `fifo_empty_i` when `tx_dir_i`=0 (receive). While a data burst is active and its limit flag is high, no beat is offered and the burst ends. The other flag has no effect.
- R7: A beat counts only on a cycle where valid and ready are both high. With ready low, valid stays high unless the FIFO limit ends the burst.
- R8: `done_o` is a one-cycle pulse. It comes in the cycle after the final handshake of a counted burst, or in the cycle after the cycle in which the FIFO limit stopped the burst. No beat is offered during it.
- R9: A start pulse is ignored while a burst is running or completing.
- R10: The first beat is offered in the cycle after the start pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a burst |
| desc_sel_i | input | 1 | 1 = descriptor field access, 0 = data buffer access |
| burst_len_i | input | LEN_W | Data burst length code; 0 = no limit |
| tx_dir_i | input | 1 | 1 = transmit (limited by FIFO full), 0 = receive (limited by FIFO empty) |
| fifo_full_i | input | 1 | Transmit data FIFO has no free entry |
| fifo_empty_i | input | 1 | Receive data FIFO holds no entry |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | The bus accepts the offered beat |
| beat_last_o | output | 1 | The offered beat is the final one of a counted burst |
| done_o | output | 1 | One-cycle pulse marking the end of a burst |

## Verification
The assertions check several rules on every cycle. An offered beat that is not accepted is kept, unless the FIFO limit ends the burst. No beat is offered against a full transmit FIFO or an empty receive FIFO. The last marker never appears without valid, and never in an unlimited burst. The completion pulse lasts one cycle and follows a final handshake. The scenarios alone show the exact beat counts: per descriptor width, per legal length code, for rounded illegal codes, and for unlimited or cut-short bursts. They also show that a start pulse during a burst is ignored, and that the first beat comes one cycle after the start.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dbs_state_e;
endpackage

// File: rtl/dbs_len_legalize.sv
// Maps a raw length code onto the highest power of two not above it.
// Zero stays zero (meaning "no limit").
module dbs_len_legalize #(
  parameter int LEN_W = 6
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] limit_o
);
  always_comb begin
    limit_o = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (len_i[i]) limit_o = LEN_W'(1) << i;
    end
  end
endmodule

// File: rtl/dbs_beat_counter.sv
module dbs_beat_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_last_o = (cnt_q == (limit_i - CNT_W'(1)));
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int DESC_BEATS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             desc_sel_i,
  input  logic             tx_dir_i,
  input  logic [CNT_W-1:0] data_limit_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic             beat_ready_i,
  input  logic             cnt_last_i,
  output logic             beat_valid_o,
  output logic             beat_last_o,
  output logic             done_o,
  output logic             cnt_clear_o,
  output logic             cnt_step_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             desc_q_o,
  output logic             tx_q_o,
  output logic             unl_q_o
);
  dbs_state_e st_q, st_d;
  logic       blocked;
  logic       hs;
  logic       accept;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign blocked = !desc_q_o && (tx_q_o ? fifo_full_i : fifo_empty_i);

  assign beat_valid_o = (st_q == ST_RUN) && !blocked;
  assign hs           = beat_valid_o && beat_ready_i;
  assign beat_last_o  = beat_valid_o && !unl_q_o && cnt_last_i;
  assign done_o       = (st_q == ST_DONE);
  assign cnt_clear_o  = accept;
  assign cnt_step_o   = hs;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN: begin
        if (blocked)                st_d = ST_DONE;
        else if (hs && beat_last_o) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      desc_q_o <= 1'b0;
      tx_q_o   <= 1'b0;
      unl_q_o  <= 1'b0;
      limit_o  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        desc_q_o <= desc_sel_i;
        tx_q_o   <= tx_dir_i;
        unl_q_o  <= !desc_sel_i && (data_limit_i == '0);
        limit_o  <= desc_sel_i ? CNT_W'(DESC_BEATS) : data_limit_i;
      end
    end
  end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             desc_sel_i,
  input  logic [LEN_W-1:0] burst_len_i,
  input  logic             tx_dir_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  output logic             beat_valid_o,
  input  logic             beat_ready_i,
  output logic             beat_last_o,
  output logic             done_o
);
  localparam int DESC_BEATS = 32 / DATA_W;

  logic [LEN_W-1:0] data_limit;
  logic [LEN_W-1:0] limit_q;
  logic             cnt_clear;
  logic             cnt_step;
  logic             cnt_last;
  logic             desc_q;
  logic             tx_q;
  logic             unl_q;

  dbs_len_legalize #(.LEN_W(LEN_W)) u_legal (
    .len_i   (burst_len_i),
    .limit_o (data_limit)
  );

  dbs_beat_counter #(.CNT_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (cnt_clear),
    .step_i    (cnt_step),
    .limit_i   (limit_q),
    .at_last_o (cnt_last)
  );

  dbs_ctrl #(.CNT_W(LEN_W), .DESC_BEATS(DESC_BEATS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .desc_sel_i   (desc_sel_i),
    .tx_dir_i     (tx_dir_i),
    .data_limit_i (data_limit),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .beat_ready_i (beat_ready_i),
    .cnt_last_i   (cnt_last),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .done_o       (done_o),
    .cnt_clear_o  (cnt_clear),
    .cnt_step_o   (cnt_step),
    .limit_o      (limit_q),
    .desc_q_o     (desc_q),
    .tx_q_o       (tx_q),
    .unl_q_o      (unl_q)
  );
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_full_i,
  input logic fifo_empty_i,
  input logic beat_valid_o,
  input logic beat_ready_i,
  input logic beat_last_o,
  input logic done_o,
  input logic desc_q,
  input logic tx_q,
  input logic unl_q
);
  logic data_blocked;
  assign data_blocked = !desc_q && (tx_q ? fifo_full_i : fifo_empty_i);

  p_last_has_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  p_no_last_unlimited_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> !unl_q);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !desc_q && tx_q) |-> !fifo_full_i);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !desc_q && !tx_q) |-> !fifo_empty_i);

  p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o || data_blocked));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && beat_last_o) |=> done_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !beat_valid_o);
endmodule

bind dma_burst_seq dma_burst_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_last_o  (beat_last_o),
  .done_o       (done_o),
  .desc_q       (desc_q),
  .tx_q         (tx_q),
  .unl_q        (unl_q)
);

// File: tb/dma_burst_seq_tb_top.sv
module dma_burst_seq_tb_top;
  localparam int DW     = 8;
  localparam int DESC_N = 32 / DW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       desc_sel_i = 1'b0;
  logic [5:0] burst_len_i = '0;
  logic       tx_dir_i = 1'b0;
  logic       fifo_full_i = 1'b0;
  logic       fifo_empty_i = 1'b0;
  logic       beat_ready_i = 1'b0;
  logic       beat_valid_o, beat_last_o, done_o;

  always #10 clk = ~clk;

  dma_burst_seq #(.DATA_W(DW), .LEN_W(6)) dut_i (.*);

  int    vectors = 0;
  int    errors  = 0;
  int    hs_cnt  = 0;
  bit    done_seen = 1'b0;
  bit    last_hs_prev = 1'b0;
  bit    finished = 1'b0;
  int    exp_q[$];   // 0 = plain beat, 1 = last beat, 2 = done
  string tag_q[$];

  function automatic void check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  // Monitor: samples 1 ns before each rising edge.
  initial forever begin
    @(negedge clk);
    #9;
    if (rst_n) begin
      if (last_hs_prev) check(done_o == 1'b1, "R8", "done after last beat", int'(done_o), 1);
      last_hs_prev = 1'b0;
      if (beat_valid_o && beat_ready_i) begin
        hs_cnt++;
        if (beat_last_o) last_hs_prev = 1'b1;
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected beat", 1, 0);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(int'(beat_last_o) == e, t, "beat/last item", int'(beat_last_o), e);
        end
      end
      if (done_o) begin
        done_seen = 1'b1;
        if (exp_q.size() == 0) check(1'b0, "R8", "unexpected done", 2, 0);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(e == 2, t, "done item", 2, e);
        end
      end
    end
  end

  task automatic drive_flags(input bit tx, input int stop_after);
    bit lim;
    lim = (stop_after >= 0) && (hs_cnt >= stop_after);
    if (tx) begin fifo_full_i = lim; fifo_empty_i = 1'b1; end
    else    begin fifo_empty_i = lim; fifo_full_i = 1'b1; end
  endtask

  task automatic burst(input bit desc, input logic [5:0] len, input bit tx,
                       input int nbeats, input bit has_last, input int stop_after,
                       input int stall, input bit poke, input string tag);
    int  cyc;
    bit  poked;
    for (int i = 0; i < nbeats; i++) begin
      exp_q.push_back((has_last && i == nbeats - 1) ? 1 : 0);
      tag_q.push_back(tag);
    end
    exp_q.push_back(2); tag_q.push_back("R8");
    hs_cnt = 0; done_seen = 1'b0; cyc = 0; poked = 1'b0;
    @(negedge clk);
    desc_sel_i = desc; burst_len_i = len; tx_dir_i = tx;
    drive_flags(tx, stop_after);
    beat_ready_i = (stall == 0);
    start_i = 1'b1;
    while (!done_seen && cyc < 300) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (poke && !poked && hs_cnt >= 1) begin
        start_i = 1'b1; burst_len_i = 6'd32; desc_sel_i = 1'b0; poked = 1'b1;
      end
      beat_ready_i = (stall == 0) || (cyc % stall != 0);
      drive_flags(tx, stop_after);
    end
    start_i = 1'b0; beat_ready_i = 1'b0;
    fifo_full_i = 1'b0; fifo_empty_i = 1'b0;
    check(cyc < 300, tag, "burst finished", cyc, 0);
    @(negedge clk);
    #9;
    check(exp_q.size() == 0, tag, "items left over", exp_q.size(), 0);
    check(!beat_valid_o, tag, "idle after done", int'(beat_valid_o), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #9;
    check(!beat_valid_o, "R1", "valid in reset", int'(beat_valid_o), 0);
    check(!beat_last_o,  "R1", "last in reset",  int'(beat_last_o), 0);
    check(!done_o,       "R1", "done in reset",  int'(done_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #9;
    check(!beat_valid_o && !done_o, "R1", "quiet after reset", int'(beat_valid_o), 0);

    // R10 and R7: first beat timing, hold under back-pressure
    exp_q.push_back(0); tag_q.push_back("R10");
    exp_q.push_back(0); tag_q.push_back("R10");
    exp_q.push_back(0); tag_q.push_back("R10");
    exp_q.push_back(1); tag_q.push_back("R10");
    exp_q.push_back(2); tag_q.push_back("R8");
    hs_cnt = 0; done_seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1; desc_sel_i = 1'b0; burst_len_i = 6'd4; tx_dir_i = 1'b0;
    fifo_full_i = 1'b0; fifo_empty_i = 1'b0; beat_ready_i = 1'b0;
    #9 check(!beat_valid_o, "R10", "no beat in start cycle", int'(beat_valid_o), 0);
    @(negedge clk); start_i = 1'b0;
    #9 check(beat_valid_o, "R10", "beat one cycle after start", int'(beat_valid_o), 1);
    @(negedge clk);
    #9 check(beat_valid_o, "R7", "beat held with ready low", int'(beat_valid_o), 1);
    @(negedge clk); beat_ready_i = 1'b1;
    for (int k = 0; k < 20 && !done_seen; k++) @(negedge clk);
    beat_ready_i = 1'b0;
    @(negedge clk); #9;
    check(exp_q.size() == 0, "R7", "directed items left", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();

    // R2: descriptor bursts, both FIFO flags high
    burst(1'b1, 6'd0,  1'b1, DESC_N, 1'b1, 0, 0, 1'b0, "R2");
    burst(1'b1, 6'd16, 1'b0, DESC_N, 1'b1, 0, 2, 1'b0, "R2");
    // R3: legal lengths, some with stalls (R7)
    burst(1'b0, 6'd1,  1'b1, 1,  1'b1, -1, 0, 1'b0, "R3");
    burst(1'b0, 6'd2,  1'b0, 2,  1'b1, -1, 0, 1'b0, "R3");
    burst(1'b0, 6'd4,  1'b1, 4,  1'b1, -1, 3, 1'b0, "R7");
    burst(1'b0, 6'd8,  1'b0, 8,  1'b1, -1, 0, 1'b0, "R3");
    burst(1'b0, 6'd16, 1'b1, 16, 1'b1, -1, 2, 1'b0, "R7");
    burst(1'b0, 6'd32, 1'b0, 32, 1'b1, -1, 0, 1'b0, "R3");
    // R4: illegal codes round down
    burst(1'b0, 6'd3,  1'b1, 2,  1'b1, -1, 0, 1'b0, "R4");
    burst(1'b0, 6'd5,  1'b0, 4,  1'b1, -1, 0, 1'b0, "R4");
    burst(1'b0, 6'd40, 1'b1, 32, 1'b1, -1, 0, 1'b0, "R4");
    burst(1'b0, 6'd63, 1'b0, 32, 1'b1, -1, 4, 1'b0, "R4");
    // R5: unlimited length, FIFO ends it
    burst(1'b0, 6'd0, 1'b1, 7,  1'b0, 7, 0, 1'b0, "R5");
    burst(1'b0, 6'd0, 1'b0, 3,  1'b0, 3, 3, 1'b0, "R5");
    burst(1'b0, 6'd0, 1'b1, 40, 1'b0, 40, 0, 1'b0, "R5");
    burst(1'b0, 6'd0, 1'b0, 0,  1'b0, 0, 0, 1'b0, "R5");
    // R6: counted bursts cut short by FIFO
    burst(1'b0, 6'd16, 1'b1, 5, 1'b0, 5, 0, 1'b0, "R6");
    burst(1'b0, 6'd8,  1'b0, 0, 1'b0, 0, 0, 1'b0, "R6");
    burst(1'b0, 6'd8,  1'b0, 6, 1'b0, 6, 2, 1'b0, "R6");
    // R9: start pulse during a burst is ignored
    burst(1'b0, 6'd4, 1'b1, 4, 1'b1, -1, 0, 1'b1, "R9");
    burst(1'b1, 6'd0, 1'b0, DESC_N, 1'b1, 0, 2, 1'b1, "R9");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule